// File: doc/BRIEF.md
# Manchester Word Encoder with Transmit Sequencer

This block serializes one 16-bit word into a Manchester II frame. The frame is three bit times of sync, sixteen data bits sent most significant bit first, and an odd parity bit. One frame takes exactly twenty bit periods. The block runs from a 12 MHz system clock. It divides that clock by twelve to get a 1 MHz bit clock, and each half of a Manchester bit lasts six system clocks.

A host stages a word in a first-rank register and then commits it to a second-rank register. The sequencer copies the second rank into its shifter when the data window opens. While the window is open, the second rank is locked, so the host can stage the next word of a multi-word message in the gap between windows. The enable input is active low and is checked once near the end of every frame. If it is still low, the next frame follows with no gap.

A message-length watchdog counts the bit periods of a continuous message. If the message would run past its limit, the watchdog cuts the transmission and raises a fail-safe flag. The flag blocks new transmissions until the host reports a valid command for this terminal, or until master reset.

Top module: `manchester_word_encoder`

## Requirements
- R1: `bit_clk` has a period of DIV system clocks (12 by default). It is low for the first DIV/2 clocks after reset and after every falling edge, and high for the rest. Its falling edge marks the start of a bit period.
- R2: When the block is idle, `tx_go_n` is low at a falling edge of `bit_clk` and `fail_safe` is low, `tx_busy` rises at that edge. A frame lasts 20 bit periods, numbered 0 to 19.
- R3: `send_win` rises at the start of bit period 3 (the fourth falling edge of the frame). It stays high for exactly 16 bit periods (192 system clocks) and falls at the start of period 19.
- R4: `ser_out` shows the symbol of bit period k during bit period k+1. That is one bit period of latency. The symbol's first level lasts for the first six clocks of the period and its second level for the last six. `ser_out` is low whenever no symbol is being sent.
- R5: `sync_cmd_sel` is sampled at the `bit_clk` rising edge in period 0. A 1 gives a command/status sync: high for 1.5 bit times, then low for 1.5 bit times. A 0 gives a data sync, which is the inverse.
- R6: Periods 3 to 18 carry data bits 15 down to 0. A 1 is sent as high then low, and a 0 as low then high. Period 19 carries a parity bit chosen so that the 17 bits have an odd number of ones.
- R7: The first rank takes `data_in` on every clock with `stage_en` high. The second rank takes the first rank on every clock with `load_n` low and `send_win` low, and it ignores `load_n` while `send_win` is high. The word sent is the second rank as it stands when `send_win` rises.
- R8: `tx_go_n` is sampled at the `bit_clk` rising edge in period 19. If it is low, a new frame begins at the next falling edge with its sync sampled again. If it is high, `tx_busy` falls at that edge.
- R9: A message that would continue past LIMIT bit periods (768 by default) is cut at the end of its LIMIT-th period. At that edge `tx_busy` and `send_win` fall, `ser_out` goes idle and `fail_safe` rises.
- R10: While `fail_safe` is high no frame starts. A clock with `own_cmd_ok` high clears the flag, unless the same clock trips the watchdog.
- R11: When `rst_n` goes low, all outputs go low at once and the divider restarts. The reset overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| tx_go_n | input | 1 | Transmit enable, active low |
| sync_cmd_sel | input | 1 | 1 = command/status sync, 0 = data sync |
| data_in | input | 16 | Parallel word to stage |
| stage_en | input | 1 | Loads the first rank from `data_in` |
| load_n | input | 1 | Active-low commit of the first rank into the second rank |
| own_cmd_ok | input | 1 | A valid command for this terminal was received; clears `fail_safe` |
| bit_clk | output | 1 | 1 MHz bit clock |
| send_win | output | 1 | High while the 16 data bits are being sent |
| ser_out | output | 1 | Manchester line output, low when idle |
| tx_busy | output | 1 | A frame is in progress |
| fail_safe | output | 1 | The message-length watchdog has tripped |

## Verification
The assertions assume that `rst_n` is released away from the rising clock edge. They also assume that `own_cmd_ok` is a pulse from logic in the same clock domain. They assume nothing about when the host moves `load_n` or `tx_go_n`, because the lockout and the sampling points do not depend on host timing. The stimulus changes every input one nanosecond after a falling clock edge. It pulses `load_n` while `send_win` is high to exercise the lockout. It holds `tx_go_n` low through 39 frames so that the watchdog trips in the middle of a word, and it drops reset in the middle of a frame.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  localparam int WORD_W     = 16;
  localparam int SYNC_BITS  = 3;
  localparam int CYCLE_BITS = SYNC_BITS + WORD_W + 1;
  localparam int POS_W      = $clog2(CYCLE_BITS);

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [WORD_W-1:0] word_t;

  // two half-bit line levels of one bit period
  typedef struct packed {
    logic early;
    logic late;
  } halfbit_t;

  localparam pos_t DATA_FIRST = pos_t'(SYNC_BITS);
  localparam pos_t DATA_LAST  = pos_t'(SYNC_BITS + WORD_W - 1);
  localparam pos_t PAR_POS    = pos_t'(CYCLE_BITS - 1);

  function automatic logic odd_parity(input word_t w);
    return ~^w;
  endfunction

  function automatic halfbit_t manch(input logic b);
    halfbit_t s;
    s.early = b;
    s.late  = ~b;
    return s;
  endfunction

  // cmd=1: HH, HL, LL over the three sync periods; cmd=0 the inverse
  function automatic halfbit_t sync_half(input logic cmd, input pos_t pos);
    halfbit_t s;
    if (pos == pos_t'(0)) begin
      s.early = cmd;  s.late = cmd;
    end else if (pos == pos_t'(1)) begin
      s.early = cmd;  s.late = ~cmd;
    end else begin
      s.early = ~cmd; s.late = ~cmd;
    end
    return s;
  endfunction

  function automatic halfbit_t symbol_at(input pos_t pos, input logic cmd, input word_t w);
    word_t sh;
    if (pos < DATA_FIRST) begin
      return sync_half(cmd, pos);
    end else if (pos <= DATA_LAST) begin
      sh = w << (pos - DATA_FIRST);
      return manch(sh[WORD_W-1]);
    end else begin
      return manch(odd_parity(w));
    end
  endfunction
endpackage

// File: rtl/mwe_bit_divider.sv
module mwe_bit_divider #(
  parameter int DIV = 12,
  localparam int PW = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          fall_tick,
  output logic          rise_tick,
  output logic          bit_clk
);
  localparam logic [PW-1:0] LAST_V  = PW'(DIV - 1);
  localparam logic [PW-1:0] HALF_V  = PW'(DIV / 2);
  localparam logic [PW-1:0] PRE_HI  = PW'(DIV / 2 - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (phase_q == LAST_V) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  assign phase     = phase_q;
  assign fall_tick = (phase_q == LAST_V);   // next edge starts a bit period
  assign rise_tick = (phase_q == PRE_HI);   // next edge is the mid-bit rise
  assign bit_clk   = (phase_q >= HALF_V);

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST_V);
  assert_bitclk_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_clk) |-> $past(fall_tick));
endmodule

// File: rtl/mwe_tx_ranks.sv
module mwe_tx_ranks
  import mwe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stage_en,
  input  logic  load_n,
  input  logic  lock,
  input  word_t data_in,
  output word_t rank2
);
  word_t rank1_q, rank2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank1_q <= '0;
      rank2_q <= '0;
    end else begin
      if (stage_en)        rank1_q <= data_in;
      if (!load_n && !lock) rank2_q <= rank1_q;
    end
  end

  assign rank2 = rank2_q;

  assert_rank2_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(rank2_q));
endmodule

// File: rtl/mwe_failsafe.sv
module mwe_failsafe #(
  parameter int LIMIT = 768,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_tick,
  input  logic busy,
  input  logic ending,
  input  logic clear_req,
  output logic trip,
  output logic fail_safe
);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] len_q;
  logic          fail_q;

  assign trip = fall_tick && busy && !ending && (len_q == LIM_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  len_q <= '0;
    else if (!busy)                              len_q <= '0;
    else if (fall_tick && (trip || ending))      len_q <= '0;
    else if (fall_tick)                          len_q <= len_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fail_q <= 1'b0;
    else if (trip)      fail_q <= 1'b1;
    else if (clear_req) fail_q <= 1'b0;
  end

  assign fail_safe = fail_q;

  assert_msg_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LIM_M1);
  assert_trip_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> fail_q);
endmodule

// File: rtl/mwe_sequencer.sv
module mwe_sequencer
  import mwe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fall_tick,
  input  logic  rise_tick,
  input  logic  go_n,
  input  logic  sync_sel,
  input  logic  fail_safe,
  input  logic  trip,
  input  word_t rank2,
  output logic  busy,
  output pos_t  pos,
  output logic  send_win,
  output logic  sync_cmd,
  output word_t tx_word,
  output logic  ending
);
  logic  busy_q, send_q, cmd_q, cont_q;
  pos_t  pos_q;
  word_t word_q;

  assign ending = busy_q && (pos_q == PAR_POS) && !cont_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      send_q <= 1'b0;
      cmd_q  <= 1'b0;
      cont_q <= 1'b0;
      pos_q  <= '0;
      word_q <= '0;
    end else begin
      if (rise_tick && busy_q && pos_q == pos_t'(0))  cmd_q  <= sync_sel;
      if (rise_tick && busy_q && pos_q == PAR_POS)    cont_q <= ~go_n;
      if (fall_tick) begin
        if (busy_q) begin
          if (trip) begin
            busy_q <= 1'b0;
            send_q <= 1'b0;
            pos_q  <= '0;
          end else if (pos_q == PAR_POS) begin
            pos_q <= '0;
            if (!cont_q) busy_q <= 1'b0;
          end else begin
            pos_q <= pos_q + 1'b1;
            if (pos_q == DATA_FIRST - 1'b1) begin
              send_q <= 1'b1;
              word_q <= rank2;
            end
            if (pos_q == DATA_LAST) send_q <= 1'b0;
          end
        end else if (!go_n && !fail_safe) begin
          busy_q <= 1'b1;
          pos_q  <= '0;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign pos      = pos_q;
  assign send_win = send_q;
  assign sync_cmd = cmd_q;
  assign tx_word  = word_q;

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= PAR_POS);
  assert_send_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    send_q |-> busy_q);
  assert_send_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_q) |-> $past(fall_tick));
endmodule

// File: rtl/manchester_word_encoder.sv
module manchester_word_encoder
  import mwe_pkg::*;
#(
  parameter int DIV   = 12,
  parameter int LIMIT = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_go_n,
  input  logic              sync_cmd_sel,
  input  logic [WORD_W-1:0] data_in,
  input  logic              stage_en,
  input  logic              load_n,
  input  logic              own_cmd_ok,
  output logic              bit_clk,
  output logic              send_win,
  output logic              ser_out,
  output logic              tx_busy,
  output logic              fail_safe
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] HALF_V = PW'(DIV / 2);

  logic [PW-1:0] phase;
  logic          fall_tick, rise_tick;
  logic          busy, ending, trip, sync_cmd;
  pos_t          pos;
  word_t         rank2, tx_word;
  halfbit_t      sym_q;
  logic          sym_on_q;

  mwe_bit_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .fall_tick(fall_tick), .rise_tick(rise_tick), .bit_clk(bit_clk)
  );

  mwe_tx_ranks u_ranks (
    .clk(clk), .rst_n(rst_n), .stage_en(stage_en), .load_n(load_n),
    .lock(send_win), .data_in(data_in), .rank2(rank2)
  );

  mwe_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .go_n(tx_go_n), .sync_sel(sync_cmd_sel), .fail_safe(fail_safe), .trip(trip),
    .rank2(rank2), .busy(busy), .pos(pos), .send_win(send_win),
    .sync_cmd(sync_cmd), .tx_word(tx_word), .ending(ending)
  );

  mwe_failsafe #(.LIMIT(LIMIT)) u_fs (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .busy(busy),
    .ending(ending), .clear_req(own_cmd_ok), .trip(trip), .fail_safe(fail_safe)
  );

  // symbol of the period that is ending is shown during the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q    <= '0;
      sym_on_q <= 1'b0;
    end else if (fall_tick) begin
      if (busy && !trip) begin
        sym_q    <= symbol_at(pos, sync_cmd, tx_word);
        sym_on_q <= 1'b1;
      end else begin
        sym_q    <= '0;
        sym_on_q <= 1'b0;
      end
    end
  end

  assign ser_out = sym_on_q && ((phase >= HALF_V) ? sym_q.late : sym_q.early);
  assign tx_busy = busy;

  assert_line_half_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out) |-> (phase == '0 || phase == HALF_V));
  assert_no_start_in_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fail_safe) |-> !$rose(tx_busy));
endmodule

// File: tb/test_manchester_word_encoder.sv
module test_manchester_word_encoder;
  localparam int DIV = 12;
  localparam int LIM = 768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_go_n = 1'b1, sync_cmd_sel = 1'b0, stage_en = 1'b0, load_n = 1'b1, own_cmd_ok = 1'b0;
  logic [15:0] data_in = '0;
  logic bit_clk, send_win, ser_out, tx_busy, fail_safe;

  always #4 clk = ~clk;

  manchester_word_encoder #(.DIV(DIV), .LIMIT(LIM)) i_manchester_word_encoder (
    .clk(clk), .rst_n(rst_n), .tx_go_n(tx_go_n), .sync_cmd_sel(sync_cmd_sel),
    .data_in(data_in), .stage_en(stage_en), .load_n(load_n), .own_cmd_ok(own_cmd_ok),
    .bit_clk(bit_clk), .send_win(send_win), .ser_out(ser_out),
    .tx_busy(tx_busy), .fail_safe(fail_safe)
  );

  int total = 0, fails = 0, cyc = 0;
  bit checking = 0;
  string word_tag = "R6";

  // reference model state
  int m_ph = 0, m_pos = 0, m_bits = 0;
  bit m_busy = 0, m_send = 0, m_cmd = 0, m_cont = 0, m_fail = 0;
  logic [15:0] m_r1 = '0, m_r2 = '0, m_word = '0;
  bit lvq[$];
  string tagq[$];
  bit e_line = 0;
  string e_tag = "R4";
  bit tk, rs, trip, ending, old_send;
  logic [15:0] old_r1;

  function automatic void chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic void push_pair(input bit a, input bit b, input string t);
    for (int i = 0; i < DIV; i++) begin
      lvq.push_back(i < DIV/2 ? a : b);
      tagq.push_back(t);
    end
  endfunction

  function automatic void push_symbol();
    int h;
    bit d;
    if (m_pos < 3) begin
      for (int i = 0; i < DIV; i++) begin
        h = 2*m_pos + (i < DIV/2 ? 0 : 1);
        lvq.push_back(m_cmd ? (h < 3) : (h >= 3));
        tagq.push_back("R5");
      end
    end else if (m_pos < 19) begin
      d = m_word[18 - m_pos];
      push_pair(d, !d, word_tag);
    end else begin
      d = ($countones(m_word) % 2 == 0);
      push_pair(d, !d, word_tag);
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_pos = 0; m_bits = 0; m_busy = 0; m_send = 0; m_cmd = 0; m_cont = 0;
      m_fail = 0; m_r1 = '0; m_r2 = '0; m_word = '0;
      lvq.delete(); tagq.delete(); e_line = 0; e_tag = "R11";
    end else begin
      tk = (m_ph == DIV-1);
      rs = (m_ph == DIV/2-1);
      old_send = m_send;
      old_r1 = m_r1;
      trip = 0;
      if (rs && m_busy && m_pos == 0)  m_cmd = sync_cmd_sel;
      if (rs && m_busy && m_pos == 19) m_cont = !tx_go_n;
      if (tk) begin
        if (m_busy) begin
          ending = (m_pos == 19) && !m_cont;
          trip = (m_bits + 1 >= LIM) && !ending;
          if (trip) begin
            push_pair(0, 0, "R9");
            m_busy = 0; m_send = 0; m_pos = 0; m_bits = 0; m_fail = 1;
          end else begin
            push_symbol();
            m_bits = ending ? 0 : m_bits + 1;
            if (m_pos == 19) begin
              m_pos = 0;
              if (!m_cont) m_busy = 0;
            end else begin
              m_pos++;
              if (m_pos == 3) begin m_send = 1; m_word = m_r2; end
              if (m_pos == 19) m_send = 0;
            end
          end
        end else begin
          push_pair(0, 0, "R4");
          if (!tx_go_n && !m_fail) begin m_busy = 1; m_pos = 0; m_bits = 0; end
        end
      end
      if (own_cmd_ok && !trip) m_fail = 0;
      if (!load_n && !old_send) m_r2 = old_r1;
      if (stage_en) m_r1 = data_in;
      m_ph = (m_ph + 1) % DIV;
      if (lvq.size() > 0) begin e_line = lvq.pop_front(); e_tag = tagq.pop_front(); end
      else begin e_line = 0; e_tag = "R4"; end
    end
    if (cyc > 150000) begin
      fails++; total++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  always @(negedge clk) if (checking) begin
    chk(bit_clk,   (m_ph >= DIV/2), "R1");
    chk(tx_busy,   m_busy, "R2");
    chk(send_win,  m_send, "R3");
    chk(ser_out,   e_line, e_tag);
    chk(fail_safe, m_fail, "R9/R10");
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic stage_word(input logic [15:0] w);
    data_in = w; stage_en = 1; load_n = 0;
    step(2);
    stage_en = 0; load_n = 1;
  endtask

  initial begin
    int n;
    step(4);
    checking = 1;
    @(negedge clk);
    chk(tx_busy, 0, "R11"); chk(ser_out, 0, "R11"); chk(send_win, 0, "R11");
    chk(fail_safe, 0, "R11"); chk(bit_clk, 0, "R11");
    #1 rst_n = 1;
    step(3);

    // single command-sync word
    word_tag = "R6";
    sync_cmd_sel = 1;
    stage_word(16'hA5C3);
    tx_go_n = 0;
    while (!tx_busy) @(negedge clk);
    #1 tx_go_n = 1;
    while (!send_win) @(negedge clk);
    n = 0;
    while (send_win) begin n++; @(negedge clk); end
    total++;
    if (n != 192) begin fails++; $display("FAIL R3 window clocks actual=%0d expected=192", n); end
    while (tx_busy) @(negedge clk);
    step(30);

    // three-word data-sync message with locked reload attempts
    word_tag = "R7/R8";
    sync_cmd_sel = 0;
    stage_word(16'h0001);
    tx_go_n = 0;
    for (int k = 0; k < 2; k++) begin
      while (!send_win) @(negedge clk);
      #1;
      data_in = 16'h1234; stage_en = 1; load_n = 0;
      step(3);
      stage_en = 0; load_n = 1;
      while (send_win) @(negedge clk);
      #1;
      stage_word(k == 0 ? 16'hFFFE : 16'h8000);
    end
    while (!send_win) @(negedge clk);
    #1 tx_go_n = 1;
    while (tx_busy) @(negedge clk);
    step(30);

    // continuous message until the watchdog cuts it
    word_tag = "R9";
    sync_cmd_sel = 1;
    stage_word(16'h5A5A);
    tx_go_n = 0;
    while (!fail_safe) @(negedge clk);
    chk(tx_busy, 0, "R9"); chk(send_win, 0, "R9");
    step(100);
    @(negedge clk);
    chk(tx_busy, 0, "R10"); chk(fail_safe, 1, "R10");
    #1 own_cmd_ok = 1;
    step(1);
    own_cmd_ok = 0;
    @(negedge clk);
    chk(fail_safe, 0, "R10");
    word_tag = "R8";
    while (!tx_busy) @(negedge clk);
    #1 tx_go_n = 1;
    while (tx_busy) @(negedge clk);
    step(24);

    // reset in the middle of a word
    word_tag = "R6";
    tx_go_n = 0;
    while (!send_win) @(negedge clk);
    step(20);
    rst_n = 0;
    @(negedge clk);
    chk(tx_busy, 0, "R11"); chk(send_win, 0, "R11"); chk(ser_out, 0, "R11");
    chk(bit_clk, 0, "R11");
    #1 tx_go_n = 1;
    step(3);
    rst_n = 1;
    step(40);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule